// File: doc/BRIEF.md
# Dual-Channel High/Low Count PWM

This block produces two independent pulse-width-modulated outputs. Each channel has its own prescaler chain: a source multiplexer picks one of four tick-enable inputs, a 7-bit divider slows the selected ticks, and a gate decides whether the divided ticks reach the channel. A sequencer then holds the channel output high for a programmed number of prescaled ticks, followed by a programmed number of low ticks. It then repeats.

Software uses a flat 32-bit register interface with three words. There is one count word per channel, carrying the high-phase and low-phase tick counts. A single shared control word holds the enable, source select, divide ratio and gate bit of both channels. There is no polarity bit. An inverted waveform is produced by exchanging the two counts.

Top module: `dual_hilo_pwm`

## Requirements
- R1: Registers are decoded from `addr[3:2]`: word 0 (offset 0x0) is the channel A count word, word 1 (offset 0x4) is the channel B count word, and word 2 (offset 0x8) is the control word. Count words read back all 32 bits as written. The control word keeps only the bits under mask 0x00FFFFF3. Offset 0xC reads 0.
- R2: In a count word, bits 31:16 are the high-phase count H and bits 15:0 are the low-phase count L. While a channel runs, its output is high for H prescaled ticks and then low for L ticks, giving a period of H+L ticks. The first period after enabling starts with the high phase.
- R3: The divider field (channel A bits 14:8, channel B bits 22:16) holding value D yields one prescaled tick for every D+1 ticks of the selected source. D=0 passes every source tick through.
- R4: The source select field (channel A bits 5:4, channel B bits 7:6) holding value S routes `src_tick[S]` into that channel's divider. A source that is tied low stops the channel's count.
- R5: The gate bit (bit 15 for A, bit 23 for B) must be 1 for prescaled ticks to reach the sequencer. While the gate is 0, an enabled output holds its level.
- R6: Control bit 0 enables channel A and bit 1 enables channel B. When a channel's enable bit is cleared, its output is low from the next cycle on, whatever point of the period it had reached.
- R7: H=0 gives a constantly low output. L=0 with H>0 gives a constantly high output.
- R8: A count word written while its channel runs takes effect only at the next period boundary. The current period finishes with the old counts.
- R9: Each time an enable bit goes from 0 to 1, the channel restarts at the first tick of the high phase, using the counts present at that moment.
- R10: The two channels are independent. Settings and activity on one channel never change the other channel's output.
- R11: After synchronous active-low reset, all three registers read 0 and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick | input | 4 | Tick enables of the four selectable sources |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte offset of the register word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pwm_out | output | 2 | Channel outputs, bit 0 is A, bit 1 is B |

## Verification
The bench sweeps all high and low counts from 0 to 3 against divide values 0 to 2, and compares every cycle with an arithmetic model. A design that dropped the high phase at H=0, wrapped early at L=0, or divided by D instead of D+1 would show up as a shifted or stretched waveform. Mid-period count writes, disable in mid-high, and re-enable are each timed so that relatching too early, finishing the period before going low, or resuming from the old phase produce a wrong level on a known cycle. A tied-off source, a closed gate and a second channel running on its own settings each expose cross-wiring of the select, gate or channel fields as unexpected toggling.

// File: rtl/hilo_pwm_pkg.sv
// Shared constants for the dual high/low count PWM.
// Assumes word-aligned accesses; only addr[3:2] selects a word.
package hilo_pwm_pkg;
    localparam int DATA_W  = 32;
    localparam int CNT_W   = 16;
    localparam int DIV_W   = 7;
    localparam int NSRC    = 4;
    localparam int NCH     = 2;
    localparam int SEL_W   = $clog2(NSRC);

    localparam logic [1:0] WORD_CNT_A = 2'd0;
    localparam logic [1:0] WORD_CNT_B = 2'd1;
    localparam logic [1:0] WORD_CTRL  = 2'd2;

    // Implemented bits of the control word.
    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h00FF_FFF3;

    // Bit positions within the control word, per channel.
    function automatic int en_bit(input int ch);
        return ch;
    endfunction
    function automatic int sel_lsb(input int ch);
        return 4 + SEL_W * ch;
    endfunction
    function automatic int div_lsb(input int ch);
        return 8 + 8 * ch;
    endfunction
    function automatic int gate_bit(input int ch);
        return 15 + 8 * ch;
    endfunction
endpackage

// File: rtl/hilo_pwm_regs.sv
// Register file: two count words and one shared control word.
// Assumes one write per cycle; unimplemented bits store and read as 0.
module hilo_pwm_regs
    import hilo_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] cnt_a_q,
    output logic [DATA_W-1:0] cnt_b_q,
    output logic [DATA_W-1:0] ctrl_q
);
    logic [1:0] word;
    assign word = addr[3:2];

    // Store written words; reset clears everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_a_q <= '0;
            cnt_b_q <= '0;
            ctrl_q  <= '0;
        end else if (wr_en) begin
            case (word)
                WORD_CNT_A: cnt_a_q <= wdata;
                WORD_CNT_B: cnt_b_q <= wdata;
                WORD_CTRL:  ctrl_q  <= wdata & CTRL_MASK;
                default:    ;
            endcase
        end
    end

    // Combinational read mux.
    always_comb begin
        case (word)
            WORD_CNT_A: rdata = cnt_a_q;
            WORD_CNT_B: rdata = cnt_b_q;
            WORD_CTRL:  rdata = ctrl_q;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/hilo_prescaler.sv
// Source select, divide-by-(D+1) and gate for one channel.
// Assumes sources are single-cycle tick enables; the divider restarts
// from zero whenever the gate is closed.
module hilo_prescaler #(
    parameter int NSRC  = 4,
    parameter int DIV_W = 7,
    localparam int SEL_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_tick,
    input  logic [SEL_W-1:0] sel,
    input  logic [DIV_W-1:0] div,
    input  logic             gate,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic             src;
    logic             wrap;

    assign src  = src_tick[sel];
    assign wrap = (cnt >= div);
    assign tick = gate & src & wrap;

    // Count selected source ticks up to the divide value.
    always_ff @(posedge clk) begin
        if (!rst_n || !gate) begin
            cnt <= '0;
        end else if (src) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hilo_sequencer.sv
// High-then-low phase sequencer for one channel.
// While disabled it holds position zero and keeps tracking the count
// word, so enabling always begins a fresh high phase. Counts are
// relatched at every period boundary.
module hilo_sequencer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] hi_in,
    input  logic [CNT_W-1:0] lo_in,
    output logic             out
);
    logic [CNT_W:0]   pos;
    logic [CNT_W-1:0] hi_q;
    logic [CNT_W-1:0] lo_q;
    logic [CNT_W:0]   period;
    logic             last;

    assign period = {1'b0, hi_q} + {1'b0, lo_q};
    assign last   = (pos + 1'b1) >= period;
    assign out    = en & (pos < {1'b0, hi_q});

    // Advance position on prescaled ticks; relatch counts at boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos  <= '0;
            hi_q <= '0;
            lo_q <= '0;
        end else if (!en) begin
            pos  <= '0;
            hi_q <= hi_in;
            lo_q <= lo_in;
        end else if (tick) begin
            if (last) begin
                pos  <= '0;
                hi_q <= hi_in;
                lo_q <= lo_in;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dual_hilo_pwm.sv
// Top level: register file plus one prescaler and sequencer per channel.
// Assumes source ticks are synchronous to clk.
module dual_hilo_pwm
    import hilo_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_tick,
    input  logic              wr_en,
    input  logic [3:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NCH-1:0]    pwm_out
);
    logic [DATA_W-1:0] cnt_a_q;
    logic [DATA_W-1:0] cnt_b_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] cnt_w [NCH];
    logic [NCH-1:0]    tick_w;

    hilo_pwm_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .cnt_a_q (cnt_a_q),
        .cnt_b_q (cnt_b_q),
        .ctrl_q  (ctrl_q)
    );

    assign cnt_w[0] = cnt_a_q;
    assign cnt_w[1] = cnt_b_q;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        hilo_prescaler #(.NSRC(NSRC), .DIV_W(DIV_W)) u_pre (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_tick (src_tick),
            .sel      (ctrl_q[sel_lsb(ch) +: SEL_W]),
            .div      (ctrl_q[div_lsb(ch) +: DIV_W]),
            .gate     (ctrl_q[gate_bit(ch)]),
            .tick     (tick_w[ch])
        );

        hilo_sequencer #(.CNT_W(CNT_W)) u_seq (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (ctrl_q[en_bit(ch)]),
            .tick  (tick_w[ch]),
            .hi_in (cnt_w[ch][DATA_W-1 -: CNT_W]),
            .lo_in (cnt_w[ch][CNT_W-1:0]),
            .out   (pwm_out[ch])
        );
    end
endmodule

// File: rtl/hilo_pwm_checker.sv
// Protocol checker for dual_hilo_pwm, attached with bind.
module hilo_pwm_checker
    import hilo_pwm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [3:0]        addr,
    input logic [DATA_W-1:0] wdata,
    input logic [NSRC-1:0]   src_tick,
    input logic [NCH-1:0]    pwm_out,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [DATA_W-1:0] cnt_a_q,
    input logic [NCH-1:0]    tick_w
);
    // R1: control write stores the masked data
    p_ctrl_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[3:2] == WORD_CTRL) |=> (ctrl_q == ($past(wdata) & CTRL_MASK)));

    // R6: cleared enable keeps each output low
    p_dis_low_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[0] |-> !pwm_out[0]);
    p_dis_low_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[1] |-> !pwm_out[1]);

    // R9: first enabled cycle is the high phase unless H is zero
    p_start_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q[0]) |-> (pwm_out[0] == (cnt_a_q[31:16] != 16'd0)));

    // R5: closed gate freezes a running output
    p_gate_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[0] && !ctrl_q[15] && $past(ctrl_q[0]) && !$past(ctrl_q[15]))
        |-> $stable(pwm_out[0]));

    // R4: a prescaled tick only comes from the selected source
    p_src_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_w[0] |-> src_tick[ctrl_q[5:4]]);
endmodule

bind dual_hilo_pwm hilo_pwm_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .src_tick (src_tick),
    .pwm_out  (pwm_out),
    .ctrl_q   (ctrl_q),
    .cnt_a_q  (cnt_a_q),
    .tick_w   (tick_w)
);

// File: tb/dual_hilo_pwm_test.sv
// Self-checking bench: arithmetic waveform model, swept over small counts.
module dual_hilo_pwm_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_tick = 4'b0111;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    dual_hilo_pwm uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .pwm_out  (pwm_out)
    );

    always #4 clk = ~clk;

    localparam logic [3:0] A_OFS = 4'h0;
    localparam logic [3:0] B_OFS = 4'h4;
    localparam logic [3:0] C_OFS = 4'h8;

    // Write one word; returns at the negedge of the first cycle it is visible.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    // Model level for cycle k (1 = first enabled cycle).
    function automatic logic model(input int k, input int h, input int l, input int d);
        int p;
        p = h + l;
        if (p == 0) return 1'b0;
        return (((k - 1) / (d + 1)) % p) < h;
    endfunction

    function automatic logic [31:0] ctl_a(input int d, input int s, input bit g, input bit e);
        return (32'(g) << 15) | (32'(d) << 8) | (32'(s) << 4) | 32'(e);
    endfunction

    function automatic logic [31:0] ctl_b(input int d, input int s, input bit g, input bit e);
        return (32'(g) << 23) | (32'(d) << 16) | (32'(s) << 6) | (32'(e) << 1);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        rd_check("R11", A_OFS, 32'h0);
        rd_check("R11", B_OFS, 32'h0);
        rd_check("R11", C_OFS, 32'h0);
        check("R11", {30'd0, pwm_out}, 32'd0);

        // R1: register decode and read-back
        wr(A_OFS, 32'h0003_0005);
        wr(B_OFS, 32'hDEAD_BEEF);
        wr(C_OFS, 32'hFFFF_FFFF);
        rd_check("R1", A_OFS, 32'h0003_0005);
        rd_check("R1", B_OFS, 32'hDEAD_BEEF);
        rd_check("R1", C_OFS, 32'h00FF_FFF3);
        rd_check("R1", 4'hC, 32'h0);
        wr(C_OFS, 32'h0);
        wr(B_OFS, 32'h0);

        // R2 R3 R7 R10: sweep counts and divide on channel A, B idle
        for (int d = 0; d < 3; d++) begin
            for (int h = 0; h < 4; h++) begin
                for (int l = 0; l < 4; l++) begin
                    int n;
                    wr(C_OFS, 32'h0);
                    wr(A_OFS, (32'(h) << 16) | 32'(l));
                    wr(C_OFS, ctl_a(d, 0, 1'b1, 1'b1));
                    n = 2 * (h + l) * (d + 1) + 3;
                    for (int k = 1; k <= n; k++) begin
                        check((h == 0 || l == 0) ? "R7" : (d > 0 ? "R3" : "R2"),
                              32'(pwm_out[0]), 32'(model(k, h, l, d)));
                        check("R10", 32'(pwm_out[1]), 32'd0);
                        @(negedge clk);
                    end
                end
            end
        end

        // R4: tied-off source 3 never advances the count
        wr(C_OFS, 32'h0);
        wr(A_OFS, 32'h0001_0001);
        wr(C_OFS, ctl_a(0, 3, 1'b1, 1'b1));
        for (int k = 0; k < 8; k++) begin
            check("R4", 32'(pwm_out[0]), 32'd1);
            @(negedge clk);
        end

        // R5: closed gate holds the level
        wr(C_OFS, 32'h0);
        wr(C_OFS, ctl_a(0, 0, 1'b0, 1'b1));
        for (int k = 0; k < 8; k++) begin
            check("R5", 32'(pwm_out[0]), 32'd1);
            @(negedge clk);
        end

        // R8: mid-period count change waits for the boundary
        wr(C_OFS, 32'h0);
        wr(A_OFS, 32'h0002_0002);
        wr(C_OFS, ctl_a(0, 0, 1'b1, 1'b1));
        check("R8", 32'(pwm_out[0]), 32'd1);
        @(negedge clk);
        check("R8", 32'(pwm_out[0]), 32'd1);
        wr(A_OFS, 32'h0001_0001);
        check("R8", 32'(pwm_out[0]), 32'd0);
        @(negedge clk);
        check("R8", 32'(pwm_out[0]), 32'd0);
        @(negedge clk);
        check("R8", 32'(pwm_out[0]), 32'd1);
        @(negedge clk);
        check("R8", 32'(pwm_out[0]), 32'd0);
        @(negedge clk);
        check("R8", 32'(pwm_out[0]), 32'd1);

        // R6 R9: disable mid-high goes low at once, re-enable restarts high
        wr(C_OFS, 32'h0);
        wr(A_OFS, 32'h0003_0003);
        wr(C_OFS, ctl_a(0, 0, 1'b1, 1'b1));
        @(negedge clk);
        check("R6", 32'(pwm_out[0]), 32'd1);
        wr(C_OFS, ctl_a(0, 0, 1'b1, 1'b0));
        check("R6", 32'(pwm_out[0]), 32'd0);
        wr(C_OFS, ctl_a(0, 0, 1'b1, 1'b1));
        for (int k = 1; k <= 6; k++) begin
            check("R9", 32'(pwm_out[0]), 32'(model(k, 3, 3, 0)));
            @(negedge clk);
        end

        // R10: both channels with their own settings at once
        wr(C_OFS, 32'h0);
        wr(A_OFS, 32'h0002_0001);
        wr(B_OFS, 32'h0001_0002);
        wr(C_OFS, ctl_a(0, 0, 1'b1, 1'b1) | ctl_b(1, 2, 1'b1, 1'b1));
        for (int k = 1; k <= 20; k++) begin
            check("R10", 32'(pwm_out[0]), 32'(model(k, 2, 1, 0)));
            check("R10", 32'(pwm_out[1]), 32'(model(k, 1, 2, 1)));
            @(negedge clk);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule